// File: doc/BRIEF.md
# Composite-Field AES Forward Substitution Pipeline

This block produces the AES forward substitution of one byte per clock from logic alone, with no stored 256-byte table. The input byte is first carried by a linear change of basis into a two-level tower field. That field is pairs of GF(2^4) elements, and each GF(2^4) element is in turn a pair of GF(2^2) elements. The multiplicative inverse is formed there from GF(2^4) squaring, scaling by the constant λ = {1100}, multiplication and a small GF(2^4) inversion. The result is carried back to the standard GF(2^8) basis, and the AES affine transform is applied.

Three register stages split the datapath, so a result appears a fixed three cycles after its byte is accepted. A byte can be accepted on every cycle. Each byte carries a single valid strobe, and no back-pressure exists. The two change-of-basis matrices are derived at elaboration time from the chosen tower field, so the hardware holds only XOR networks for them.

Top module: `sbox_pipe`

## Requirements
- R1: A valid input of 0x00 is treated as having inverse 0x00 and yields 0x63 on data_o.
- R2: For every input byte x, data_o equals the affine image of x⁻¹ in GF(2^8) modulo x^8+x^4+x^3+x+1. The affine image sets output bit i to b[i]^b[(i+4)%8]^b[(i+5)%8]^b[(i+6)%8]^b[(i+7)%8]^c[i], with c = 0x63.
- R3: Input 0x53 yields 0xED, and input 0x01 yields 0x7C.
- R4: When valid_i is high at a rising clock edge, valid_o is high after the third rising edge counted from that one, with the matching result on data_o.
- R5: Bytes presented with valid_i high on consecutive cycles are all accepted, and the results emerge on consecutive cycles in input order.
- R6: When valid_i is low at an edge, valid_o is low three edges later, whatever data_i held.
- R7: While rst_ni is low, valid_o and data_o are 0. This holds from the moment of assertion, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | data_i holds a byte to substitute |
| data_i | input | 8 | Input byte |
| valid_o | output | 1 | data_o holds a result |
| data_o | output | 8 | Substituted byte |

## Verification
The assertions in the RTL check the strobe timing on every cycle, covering both the three-cycle latency and the bubbles. On every cycle they also check that the inverted GF(2^4) norm times its input gives one, and that a zero norm gives zero. They also hold the fixed points 0x00→0x63 and 0x53→0xED whenever those bytes pass through. Only the bench scenarios can show that the whole mapping is right for all 256 bytes, since that needs an independent brute-force inversion in the standard field. The same holds for back-to-back streaming order, random gaps, and the clearing of outputs by a reset asserted mid-stream.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam logic [1:0]  PHI    = 2'b10;
  localparam logic [3:0]  LAMBDA = 4'b1100;
  localparam logic [7:0]  AFF_C  = 8'h63;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0][BYTE_W-1:0] mat_t;  // [col] = image of basis bit

  // GF(2^2), z^2 = z + 1
  function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  // GF(2^4) over GF(2^2), y^2 = y + PHI
  function automatic nib_t gf16_mul(input nib_t a, input nib_t b);
    logic [1:0] hh, hl, lh, ll;
    hh = gf4_mul(a[3:2], b[3:2]);
    hl = gf4_mul(a[3:2], b[1:0]);
    lh = gf4_mul(a[1:0], b[3:2]);
    ll = gf4_mul(a[1:0], b[1:0]);
    return {hh ^ hl ^ lh, gf4_mul(hh, PHI) ^ ll};
  endfunction

  function automatic nib_t gf16_sq(input nib_t a);
    return gf16_mul(a, a);
  endfunction

  function automatic nib_t gf16_mul_lambda(input nib_t a);
    return gf16_mul(a, LAMBDA);
  endfunction

  // a^14 = a^-1 for a != 0, and 0 -> 0
  function automatic nib_t gf16_inv(input nib_t a);
    nib_t a2, a3, a6, a12;
    a2  = gf16_sq(a);
    a3  = gf16_mul(a2, a);
    a6  = gf16_sq(a3);
    a12 = gf16_sq(a6);
    return gf16_mul(a12, a2);
  endfunction

  // GF((2^4)^2), x^2 = x + LAMBDA
  function automatic byte_t gf256c_mul(input byte_t a, input byte_t b);
    nib_t hh, hl, lh, ll;
    hh = gf16_mul(a[7:4], b[7:4]);
    hl = gf16_mul(a[7:4], b[3:0]);
    lh = gf16_mul(a[3:0], b[7:4]);
    ll = gf16_mul(a[3:0], b[3:0]);
    return {hh ^ hl ^ lh, gf16_mul_lambda(hh) ^ ll};
  endfunction

  function automatic byte_t mat_apply(input mat_t m, input byte_t a);
    byte_t r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++) if (a[i]) r ^= m[i];
    return r;
  endfunction

  // Smallest tower-field root of the AES reduction polynomial
  function automatic byte_t iso_root();
    byte_t c, p2, p3, p4, p8, r;
    r = '0;
    for (int k = 255; k >= 2; k--) begin
      c  = byte_t'(k);
      p2 = gf256c_mul(c, c);
      p3 = gf256c_mul(p2, c);
      p4 = gf256c_mul(p2, p2);
      p8 = gf256c_mul(p4, p4);
      if ((p8 ^ p4 ^ p3 ^ c ^ 8'h01) == 8'h00) r = c;
    end
    return r;
  endfunction

  // Standard basis -> tower basis: column i is root^i
  function automatic mat_t iso_fwd_cols(input byte_t root);
    mat_t m;
    m[0] = 8'h01;
    for (int i = 1; i < BYTE_W; i++) m[i] = gf256c_mul(m[i-1], root);
    return m;
  endfunction

  // Tower basis -> standard basis by search over the forward map
  function automatic mat_t iso_inv_cols(input mat_t fwd);
    mat_t m;
    m = '0;
    for (int j = 0; j < BYTE_W; j++)
      for (int a = 0; a < 256; a++)
        if (mat_apply(fwd, byte_t'(a)) == byte_t'(1 << j)) m[j] = byte_t'(a);
    return m;
  endfunction

endpackage

// File: rtl/sbox_lin_map.sv
module sbox_lin_map
  import sbox_pkg::*;
#(
  parameter mat_t COLS = '0
) (
  input  logic [BYTE_W-1:0] a_i,
  output logic [BYTE_W-1:0] y_o
);
  logic [BYTE_W-1:0][BYTE_W-1:0] term;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_col
    assign term[i] = a_i[i] ? COLS[i] : '0;
  end

  always_comb begin
    y_o = '0;
    for (int i = 0; i < BYTE_W; i++) y_o ^= term[i];
  end
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
  import sbox_pkg::*;
(
  input  logic [BYTE_W-1:0] b_i,
  output logic [BYTE_W-1:0] y_o
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign y_o[i] = b_i[i] ^ b_i[(i+4)%BYTE_W] ^ b_i[(i+5)%BYTE_W]
                  ^ b_i[(i+6)%BYTE_W] ^ b_i[(i+7)%BYTE_W] ^ AFF_C[i];
  end
endmodule

// File: rtl/sbox_comp_inv.sv
module sbox_comp_inv
  import sbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] q_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] q_inv_o
);
  nib_t q_hi, q_lo, den;

  logic s1_v, s2_v;
  nib_t s1_hi, s1_sum, s1_den;
  nib_t s2_hi, s2_sum, s2_dinv;

  assign q_hi = q_i[BYTE_W-1:NIB_W];
  assign q_lo = q_i[NIB_W-1:0];
  // norm: hi^2*lambda + hi*lo + lo^2
  assign den  = gf16_mul_lambda(gf16_sq(q_hi)) ^ gf16_mul(q_hi, q_lo) ^ gf16_sq(q_lo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v   <= 1'b0;
      s1_hi  <= '0;
      s1_sum <= '0;
      s1_den <= '0;
    end else begin
      s1_v   <= valid_i;
      s1_hi  <= q_hi;
      s1_sum <= q_hi ^ q_lo;
      s1_den <= den;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v    <= 1'b0;
      s2_hi   <= '0;
      s2_sum  <= '0;
      s2_dinv <= '0;
    end else begin
      s2_v    <= s1_v;
      s2_hi   <= s1_hi;
      s2_sum  <= s1_sum;
      s2_dinv <= gf16_inv(s1_den);
    end
  end

  assign valid_o = s2_v;
  assign q_inv_o = {gf16_mul(s2_hi, s2_dinv), gf16_mul(s2_sum, s2_dinv)};

  // R2
  den_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v && (s1_den != '0)) |=> (gf16_mul($past(s1_den), s2_dinv) == 4'h1));

  // R1
  den_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_v && (s1_den == '0)) |=> (s2_dinv == '0));
endmodule

// File: rtl/sbox_pipe.sv
module sbox_pipe
  import sbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam byte_t ISO_ROOT = iso_root();
  localparam mat_t  ISO_FWD  = iso_fwd_cols(ISO_ROOT);
  localparam mat_t  ISO_INV  = iso_inv_cols(ISO_FWD);

  logic  inv_v;
  byte_t tower_q, tower_inv, std_inv, aff;

  sbox_lin_map #(.COLS(ISO_FWD)) u_map_in (
    .a_i (data_i),
    .y_o (tower_q)
  );

  sbox_comp_inv u_inv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .q_i     (tower_q),
    .valid_o (inv_v),
    .q_inv_o (tower_inv)
  );

  sbox_lin_map #(.COLS(ISO_INV)) u_map_out (
    .a_i (tower_inv),
    .y_o (std_inv)
  );

  sbox_affine u_aff (
    .b_i (std_inv),
    .y_o (aff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= inv_v;
      data_o  <= aff;
    end
  end

  // R4
  lat_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 valid_o);

  // R6
  lat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##3 !valid_o);

  // R1
  zero_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i == 8'h00) |-> ##3 (data_o == 8'h63));

  // R3
  vec_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i == 8'h53) |-> ##3 (data_o == 8'hED));
endmodule

// File: tb/sbox_pipe_test.sv
module sbox_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int WATCHDOG   = 200000;

  logic       clk_i   = 1'b0;
  logic       rst_ni  = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] data_i  = 8'h00;
  logic       valid_o;
  logic [7:0] data_o;

  int n_chk  = 0;
  int n_fail = 0;
  int hi_cnt = 0;
  bit done   = 1'b0;

  logic [7:0] ref_tab [256];
  logic       m_v [LAT];
  logic [7:0] m_d [LAT];
  logic [7:0] m_x [LAT];

  sbox_pipe uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] inv, y;
    inv = 8'h00;
    for (int c = 1; c < 256; c++)
      if (ref_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
           ^ ((8'h63 >> i) & 8'h01) != 8'h00;
    return y;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < LAT; i++) begin
      m_v[i] = 1'b0;
      m_d[i] = 8'h00;
      m_x[i] = 8'h00;
    end
  endtask

  // One cycle: check outputs against model, then drive the next input
  task automatic step(input logic v, input logic [7:0] d);
    string tag;
    @(negedge clk_i);
    chk(valid_o === m_v[LAT-1], m_v[LAT-1] ? "R4 valid_o" : "R6 valid_o",
        {7'b0, valid_o}, {7'b0, m_v[LAT-1]});
    if (m_v[LAT-1]) begin
      if (m_x[LAT-1] == 8'h00) tag = "R1 data_o";
      else if (m_x[LAT-1] == 8'h53 || m_x[LAT-1] == 8'h01) tag = "R3 data_o";
      else tag = "R2 data_o";
      chk(data_o === m_d[LAT-1], tag, data_o, m_d[LAT-1]);
    end
    if (valid_o === 1'b1) hi_cnt++;
    for (int i = LAT-1; i > 0; i--) begin
      m_v[i] = m_v[i-1];
      m_d[i] = m_d[i-1];
      m_x[i] = m_x[i-1];
    end
    m_v[0]  = v;
    m_d[0]  = ref_tab[d];
    m_x[0]  = d;
    valid_i = v;
    data_i  = d;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog act=%0d exp=%0d", WATCHDOG, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5B0C_0A1E));
    for (int x = 0; x < 256; x++) ref_tab[x] = ref_sbox(8'(x));
    clear_model();

    // Reference self-consistency against the fixed vectors
    chk(ref_tab[8'h00] == 8'h63, "R1 ref", ref_tab[8'h00], 8'h63);
    chk(ref_tab[8'h53] == 8'hED, "R3 ref", ref_tab[8'h53], 8'hED);
    chk(ref_tab[8'h01] == 8'h7C, "R3 ref", ref_tab[8'h01], 8'h7C);

    // R7: outputs held at zero in reset
    repeat (2) @(negedge clk_i);
    chk(valid_o === 1'b0, "R7 reset valid_o", {7'b0, valid_o}, 8'h00);
    chk(data_o === 8'h00, "R7 reset data_o", data_o, 8'h00);
    rst_ni = 1'b1;

    // Directed corners, isolated
    step(1'b1, 8'h00);
    repeat (LAT) step(1'b0, 8'hFF);
    step(1'b1, 8'h53);
    step(1'b0, 8'h00);
    step(1'b1, 8'h01);
    repeat (LAT + 1) step(1'b0, 8'(($urandom)));

    // R5: full sweep back to back
    hi_cnt = 0;
    for (int x = 0; x < 256; x++) step(1'b1, 8'(x));
    repeat (LAT) step(1'b0, 8'h53);
    chk(hi_cnt == 256, "R5 stream count", 8'(hi_cnt), 8'h00);

    // R2/R6: random stream with gaps; data in gaps must not leak out
    for (int n = 0; n < 2000; n++)
      step(($urandom % 3) != 0, 8'(($urandom)));
    repeat (LAT) step(1'b0, 8'h00);

    // R7: reset asserted mid-stream, between edges
    for (int n = 0; n < 4; n++) step(1'b1, 8'(($urandom)));
    #2;
    rst_ni = 1'b0;
    #1;
    chk(valid_o === 1'b0, "R7 async valid_o", {7'b0, valid_o}, 8'h00);
    chk(data_o === 8'h00, "R7 async data_o", data_o, 8'h00);
    valid_i = 1'b0;
    clear_model();
    repeat (2) step(1'b0, 8'hAA);
    rst_ni = 1'b1;

    // Recovery after reset
    step(1'b1, 8'h53);
    step(1'b1, 8'h00);
    step(1'b1, 8'hFF);
    repeat (LAT + 1) step(1'b0, 8'h11);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule